// File: doc/BRIEF.md
# Amplifier Channel Power Sequencer

This block is a host-side controller that brings a smart amplifier channel through three fixed procedures: initialisation, power-up and power-down. Each procedure is an ordered list of register writes sent out over a byte-wide write bus. The bus carries an 8-bit address and 8-bit data and uses a valid/ready handshake. The sequencer switches between the base register book and the DSP register book partway through a procedure. It inserts timed waits where the amplifier needs them. Every procedure finishes with page 0 and book 0 selected.

The host starts a procedure with a one-cycle pulse on one of three command inputs. While the procedure runs, `busy` stays high, and `done` pulses for one cycle at the end. Power-down has a mute settling wait, which can be handled in one of two ways. By default it is a fixed 10 ms wait. If `poll_mode` is high when the command is taken, the sequencer instead watches the `mute_flag` status input. In polling mode a timeout bounds the wait. When the timeout expires, `poll_err` is set and the power-down continues anyway.

Top module: `amp_pwr_seq`

## Requirements
- R1: While reset is asserted and until the first command is taken, `busy`, `done`, `wr_valid` and `poll_err` are all 0.
- R2: An init command issues exactly these writes, shown as (address, data) in hex: (00,00) (7F,00) (01,01) (7F,64) (46,01) (7F,00). Register 0x00 selects the page and register 0x7F selects the book, with 0x64 being the DSP book.
- R3: After the soft-reset write (01,01) is accepted, no write is offered for at least `RST_WAIT_US*CYC_PER_US` clock cycles.
- R4: A power-up command issues exactly (05,A3) (04,B8) (07,00) (7F,64) (07,00) (00,00) (7F,00).
- R5: A power-down command issues exactly (7F,64) (07,01) (7F,00) (07,03) (04,20) (05,00) (00,00) (04,00). This means the soft mute in the DSP book comes first and the divider register 0x04 is cleared last.
- R6: When polling is not selected, at least `MUTE_WAIT_US*CYC_PER_US` cycles pass between acceptance of the mute write (07,01) and the next write, and `mute_flag` has no effect on this wait.
- R7: When polling is selected, the write after the mute follows within a few cycles of `mute_flag` being seen at 1, without waiting for the fixed delay.
- R8: When polling is selected and `mute_flag` stays 0, the wait ends after `POLL_LIMIT_US*CYC_PER_US` cycles. At that point `poll_err` goes to 1, the power-down completes, and `poll_err` returns to 0 when the next command is taken.
- R9: Once `wr_valid` is raised, it stays high with `wr_addr` and `wr_data` unchanged until `wr_ready` is sampled high. Each handshake transfers exactly one write.
- R10: `busy` is high from the cycle after a command is taken until completion. `done` is a single-cycle pulse that appears in the same cycle as `busy` falls.
- R11: A command that arrives while `busy` is high is ignored. If several commands pulse together, the priority is init, then power-up, then power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_init | input | 1 | Start the initialisation procedure (pulse) |
| cmd_up | input | 1 | Start the power-up procedure (pulse) |
| cmd_down | input | 1 | Start the power-down procedure (pulse) |
| poll_mode | input | 1 | Use `mute_flag` polling in place of the fixed mute wait; sampled when a command is taken |
| mute_flag | input | 1 | Amplifier status: 1 once the soft mute has completed |
| wr_ready | input | 1 | Write bus can accept the current write |
| wr_valid | output | 1 | A write is offered on the bus |
| wr_addr | output | 8 | Register address of the offered write |
| wr_data | output | 8 | Data of the offered write |
| busy | output | 1 | A procedure is in progress |
| done | output | 1 | One-cycle pulse when a procedure completes |
| poll_err | output | 1 | The polling timeout expired during the last power-down |

## Verification
A wrong step index or a wrong book or page selection is visible on the very next handshake: the captured (address, data) pair differs from the expected list. The bench compares every pair, so such a fault is reported at the exact write where it occurs. A wait counter that is loaded wrongly, or that ends early, shows up at the next write as an accept-to-accept gap that is too short. A flag that is ignored shows up as a gap that is too long. A stuck or wrongly cleared control bit appears either as a missing or extra `done` pulse or as writes that keep coming after completion. The bench detects these within a few tens of cycles of the end of the sequence.

// File: rtl/amp_seq_pkg.sv
package amp_seq_pkg;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 4;

  localparam logic [ADDR_W-1:0] REG_PAGE  = 8'h00;
  localparam logic [ADDR_W-1:0] REG_BOOK  = 8'h7F;
  localparam logic [DATA_W-1:0] BOOK_BASE = 8'h00;
  localparam logic [DATA_W-1:0] BOOK_DSP  = 8'h64;

  typedef enum logic [1:0] {
    SEQ_INIT = 2'd0,
    SEQ_UP   = 2'd1,
    SEQ_DOWN = 2'd2
  } seq_e;

  typedef enum logic [1:0] {
    SK_WRITE  = 2'd0,
    SK_DELAY  = 2'd1,
    SK_MUTE   = 2'd2,
    SK_FINISH = 2'd3
  } step_kind_e;

  typedef struct packed {
    step_kind_e          kind;
    logic [ADDR_W-1:0]   addr;
    logic [DATA_W-1:0]   data;
  } step_t;

  function automatic int wait_cycles(input int us, input int cyc_per_us);
    return us * cyc_per_us;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic step_t mk_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    step_t s;
    s.kind = SK_WRITE;
    s.addr = a;
    s.data = d;
    return s;
  endfunction

  function automatic step_t mk_ctl(input step_kind_e k);
    step_t s;
    s.kind = k;
    s.addr = '0;
    s.data = '0;
    return s;
  endfunction

  // Ordered step list of each procedure
  function automatic step_t step_at(input seq_e sq, input logic [IDX_W-1:0] idx);
    step_t s;
    s = mk_ctl(SK_FINISH);
    unique case (sq)
      SEQ_INIT: begin
        case (idx)
          4'd0: s = mk_wr(REG_PAGE, 8'h00);
          4'd1: s = mk_wr(REG_BOOK, BOOK_BASE);
          4'd2: s = mk_wr(8'h01, 8'h01);
          4'd3: s = mk_ctl(SK_DELAY);
          4'd4: s = mk_wr(REG_BOOK, BOOK_DSP);
          4'd5: s = mk_wr(8'h46, 8'h01);
          4'd6: s = mk_wr(REG_BOOK, BOOK_BASE);
          default: s = mk_ctl(SK_FINISH);
        endcase
      end
      SEQ_UP: begin
        case (idx)
          4'd0: s = mk_wr(8'h05, 8'hA3);
          4'd1: s = mk_wr(8'h04, 8'hB8);
          4'd2: s = mk_wr(8'h07, 8'h00);
          4'd3: s = mk_wr(REG_BOOK, BOOK_DSP);
          4'd4: s = mk_wr(8'h07, 8'h00);
          4'd5: s = mk_wr(REG_PAGE, 8'h00);
          4'd6: s = mk_wr(REG_BOOK, BOOK_BASE);
          default: s = mk_ctl(SK_FINISH);
        endcase
      end
      SEQ_DOWN: begin
        case (idx)
          4'd0: s = mk_wr(REG_BOOK, BOOK_DSP);
          4'd1: s = mk_wr(8'h07, 8'h01);
          4'd2: s = mk_ctl(SK_MUTE);
          4'd3: s = mk_wr(REG_BOOK, BOOK_BASE);
          4'd4: s = mk_wr(8'h07, 8'h03);
          4'd5: s = mk_wr(8'h04, 8'h20);
          4'd6: s = mk_wr(8'h05, 8'h00);
          4'd7: s = mk_wr(REG_PAGE, 8'h00);
          4'd8: s = mk_wr(8'h04, 8'h00);
          default: s = mk_ctl(SK_FINISH);
        endcase
      end
      default: s = mk_ctl(SK_FINISH);
    endcase
    return s;
  endfunction

endpackage

// File: rtl/amp_seq_timer.sv
module amp_seq_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [CNT_W-1:0] load,
  output logic             expire,
  output logic             active
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (abort) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= load;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active = (cnt_q != '0);
  assign expire = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/amp_seq_wrport.sv
module amp_seq_wrport
  import amp_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [ADDR_W-1:0] issue_addr,
  input  logic [DATA_W-1:0] issue_data,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              accepted
);

  assign accepted = wr_valid && wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (issue) begin
      wr_valid <= 1'b1;
      wr_addr  <= issue_addr;
      wr_data  <= issue_data;
    end else if (accepted) begin
      wr_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/amp_seq_ctrl.sv
module amp_seq_ctrl
  import amp_seq_pkg::*;
#(
  parameter int CYC_PER_US    = 50,
  parameter int RST_WAIT_US   = 100,
  parameter int MUTE_WAIT_US  = 10000,
  parameter int POLL_LIMIT_US = 20000,
  parameter int CNT_W         = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_init,
  input  logic              cmd_up,
  input  logic              cmd_down,
  input  logic              poll_mode,
  input  logic              mute_flag,
  input  logic              wr_accepted,
  input  logic              tmr_expire,
  output logic              issue,
  output logic [ADDR_W-1:0] issue_addr,
  output logic [DATA_W-1:0] issue_data,
  output logic              tmr_start,
  output logic              tmr_abort,
  output logic [CNT_W-1:0]  tmr_load,
  output logic              cmd_taken,
  output logic              busy,
  output logic              done,
  output logic              poll_err
);

  localparam int RST_CYC  = wait_cycles(RST_WAIT_US, CYC_PER_US);
  localparam int MUTE_CYC = wait_cycles(MUTE_WAIT_US, CYC_PER_US);
  localparam int POLL_CYC = wait_cycles(POLL_LIMIT_US, CYC_PER_US);

  typedef enum logic [2:0] {
    CS_IDLE, CS_LOAD, CS_WRITE, CS_DELAY, CS_MUTE
  } cstate_e;

  cstate_e          state_q;
  seq_e             seq_q;
  logic [IDX_W-1:0] idx_q;
  logic             poll_q;
  step_t            step;
  seq_e             sel;
  logic             cmd_any;

  assign cmd_any   = cmd_init || cmd_up || cmd_down;
  assign cmd_taken = (state_q == CS_IDLE) && cmd_any;
  assign sel       = cmd_init ? SEQ_INIT : (cmd_up ? SEQ_UP : SEQ_DOWN);
  assign step      = step_at(seq_q, idx_q);

  assign issue      = (state_q == CS_LOAD) && (step.kind == SK_WRITE);
  assign issue_addr = step.addr;
  assign issue_data = step.data;
  assign tmr_start  = (state_q == CS_LOAD) &&
                      ((step.kind == SK_DELAY) || (step.kind == SK_MUTE));
  assign tmr_abort  = (state_q == CS_MUTE) && poll_q && mute_flag;

  always_comb begin
    if (step.kind == SK_DELAY) tmr_load = CNT_W'(RST_CYC);
    else if (poll_q)           tmr_load = CNT_W'(POLL_CYC);
    else                       tmr_load = CNT_W'(MUTE_CYC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= CS_IDLE;
      seq_q    <= SEQ_INIT;
      idx_q    <= '0;
      poll_q   <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      poll_err <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        CS_IDLE: begin
          if (cmd_taken) begin
            seq_q    <= sel;
            idx_q    <= '0;
            poll_q   <= poll_mode;
            busy     <= 1'b1;
            poll_err <= 1'b0;
            state_q  <= CS_LOAD;
          end
        end
        CS_LOAD: begin
          idx_q <= idx_q + 1'b1;
          unique case (step.kind)
            SK_WRITE:  state_q <= CS_WRITE;
            SK_DELAY:  state_q <= CS_DELAY;
            SK_MUTE:   state_q <= CS_MUTE;
            SK_FINISH: begin
              state_q <= CS_IDLE;
              busy    <= 1'b0;
              done    <= 1'b1;
            end
            default:   state_q <= CS_IDLE;
          endcase
        end
        CS_WRITE: begin
          if (wr_accepted) state_q <= CS_LOAD;
        end
        CS_DELAY: begin
          if (tmr_expire) state_q <= CS_LOAD;
        end
        CS_MUTE: begin
          if (poll_q) begin
            if (mute_flag) begin
              state_q <= CS_LOAD;
            end else if (tmr_expire) begin
              poll_err <= 1'b1;
              state_q  <= CS_LOAD;
            end
          end else if (tmr_expire) begin
            state_q <= CS_LOAD;
          end
        end
        default: state_q <= CS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/amp_pwr_seq.sv
module amp_pwr_seq
  import amp_seq_pkg::*;
#(
  parameter int CYC_PER_US    = 50,
  parameter int RST_WAIT_US   = 100,
  parameter int MUTE_WAIT_US  = 10000,
  parameter int POLL_LIMIT_US = 20000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_init,
  input  logic       cmd_up,
  input  logic       cmd_down,
  input  logic       poll_mode,
  input  logic       mute_flag,
  input  logic       wr_ready,
  output logic       wr_valid,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       busy,
  output logic       done,
  output logic       poll_err
);

  localparam int MAX_CYC = max3(wait_cycles(RST_WAIT_US, CYC_PER_US),
                                wait_cycles(MUTE_WAIT_US, CYC_PER_US),
                                wait_cycles(POLL_LIMIT_US, CYC_PER_US));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic              issue;
  logic [ADDR_W-1:0] issue_addr;
  logic [DATA_W-1:0] issue_data;
  logic              wr_accepted;
  logic              tmr_start;
  logic              tmr_abort;
  logic [CNT_W-1:0]  tmr_load;
  logic              tmr_expire;
  logic              tmr_active;
  logic              cmd_taken;

  amp_seq_ctrl #(
    .CYC_PER_US   (CYC_PER_US),
    .RST_WAIT_US  (RST_WAIT_US),
    .MUTE_WAIT_US (MUTE_WAIT_US),
    .POLL_LIMIT_US(POLL_LIMIT_US),
    .CNT_W        (CNT_W)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_init   (cmd_init),
    .cmd_up     (cmd_up),
    .cmd_down   (cmd_down),
    .poll_mode  (poll_mode),
    .mute_flag  (mute_flag),
    .wr_accepted(wr_accepted),
    .tmr_expire (tmr_expire),
    .issue      (issue),
    .issue_addr (issue_addr),
    .issue_data (issue_data),
    .tmr_start  (tmr_start),
    .tmr_abort  (tmr_abort),
    .tmr_load   (tmr_load),
    .cmd_taken  (cmd_taken),
    .busy       (busy),
    .done       (done),
    .poll_err   (poll_err)
  );

  amp_seq_timer #(.CNT_W(CNT_W)) timer_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tmr_start),
    .abort (tmr_abort),
    .load  (tmr_load),
    .expire(tmr_expire),
    .active(tmr_active)
  );

  amp_seq_wrport wrport_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .issue_addr(issue_addr),
    .issue_data(issue_data),
    .wr_ready  (wr_ready),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .accepted  (wr_accepted)
  );

endmodule

// File: rtl/amp_pwr_seq_chk.sv
module amp_pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [7:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       busy,
  input logic       done,
  input logic       poll_err,
  input logic       tmr_active,
  input logic       cmd_taken
);

  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R9

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_valid); // R10

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_WAIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_active |-> !wr_valid); // R3

  AST_ERR_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(poll_err) |-> busy); // R8

  AST_TAKE_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_taken |-> !busy); // R11

endmodule

bind amp_pwr_seq amp_pwr_seq_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .busy      (busy),
  .done      (done),
  .poll_err  (poll_err),
  .tmr_active(tmr_active),
  .cmd_taken (cmd_taken)
);

// File: tb/amp_pwr_seq_tb_top.sv
module amp_pwr_seq_tb_top;

  localparam int CPU      = 2;
  localparam int RST_US   = 100;
  localparam int MUTE_US  = 10000;
  localparam int POLL_US  = 20000;
  localparam int RST_N    = RST_US * CPU;
  localparam int MUTE_N   = MUTE_US * CPU;
  localparam int POLL_N   = POLL_US * CPU;
  localparam int WD_LIMIT = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_init = 1'b0, cmd_up = 1'b0, cmd_down = 1'b0;
  logic       poll_mode = 1'b0, mute_flag = 1'b0;
  logic       wr_ready = 1'b1;
  logic       wr_valid;
  logic [7:0] wr_addr, wr_data;
  logic       busy, done, poll_err;

  always #10 clk = ~clk;

  amp_pwr_seq #(
    .CYC_PER_US(CPU), .RST_WAIT_US(RST_US),
    .MUTE_WAIT_US(MUTE_US), .POLL_LIMIT_US(POLL_US)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_init(cmd_init), .cmd_up(cmd_up),
    .cmd_down(cmd_down), .poll_mode(poll_mode), .mute_flag(mute_flag),
    .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .done(done), .poll_err(poll_err)
  );

  int vecs = 0;
  int errs = 0;
  int cyc  = 0;

  logic [7:0] cap_a [32];
  logic [7:0] cap_d [32];
  int         cap_t [32];
  int         cap_n = 0;
  int         done_cnt = 0;
  int         hold_viol = 0;
  logic       hold_pend = 1'b0;
  logic [7:0] hold_a, hold_d;

  logic [7:0] exp_a [16];
  logic [7:0] exp_d [16];
  int         exp_n = 0;

  logic       stall_en = 1'b0;
  logic [6:0] lfsr = 7'h5A;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
               req, what, act, act, expv, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      errs++;
      vecs++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
      summary();
      $finish;
    end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[5:0], lfsr[6] ^ lfsr[5]};
    wr_ready <= stall_en ? lfsr[0] : 1'b1;
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (hold_pend && !(wr_valid && wr_addr == hold_a && wr_data == hold_d))
        hold_viol++;
      hold_pend = wr_valid && !wr_ready;
      hold_a = wr_addr;
      hold_d = wr_data;
      if (wr_valid && wr_ready) begin
        if (cap_n < 32) begin
          cap_a[cap_n] = wr_addr;
          cap_d[cap_n] = wr_data;
          cap_t[cap_n] = cyc;
        end
        cap_n++;
      end
      if (done) done_cnt++;
    end
  end

  task automatic load_exp(input int which);
    logic [15:0] lst [10];
    int n;
    n = 0;
    case (which)
      0: begin
        lst[0]=16'h0000; lst[1]=16'h7F00; lst[2]=16'h0101; lst[3]=16'h7F64;
        lst[4]=16'h4601; lst[5]=16'h7F00; n = 6;
      end
      1: begin
        lst[0]=16'h05A3; lst[1]=16'h04B8; lst[2]=16'h0700; lst[3]=16'h7F64;
        lst[4]=16'h0700; lst[5]=16'h0000; lst[6]=16'h7F00; n = 7;
      end
      default: begin
        lst[0]=16'h7F64; lst[1]=16'h0701; lst[2]=16'h7F00; lst[3]=16'h0703;
        lst[4]=16'h0420; lst[5]=16'h0500; lst[6]=16'h0000; lst[7]=16'h0400; n = 8;
      end
    endcase
    for (int i = 0; i < n; i++) begin
      exp_a[i] = lst[i][15:8];
      exp_d[i] = lst[i][7:0];
    end
    exp_n = n;
  endtask

  task automatic compare_stream(input string req);
    check(cap_n == exp_n, req, "write count", cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      check(cap_a[i] == exp_a[i], req, $sformatf("addr of write %0d", i), cap_a[i], exp_a[i]);
      check(cap_d[i] == exp_d[i], req, $sformatf("data of write %0d", i), cap_d[i], exp_d[i]);
    end
  endtask

  task automatic pulse(input bit i, input bit u, input bit d);
    @(negedge clk);
    cmd_init = i; cmd_up = u; cmd_down = d;
    @(negedge clk);
    cmd_init = 1'b0; cmd_up = 1'b0; cmd_down = 1'b0;
  endtask

  task automatic start_seq(input bit i, input bit u, input bit d, input string req);
    cap_n = 0;
    hold_viol = 0;
    pulse(i, u, d);
    check(busy == 1'b1, req, "busy after command", busy, 1);
  endtask

  task automatic wait_end(input int start_done, input string req);
    int guard;
    guard = 0;
    while (done_cnt == start_done && guard < 60000) begin
      @(negedge clk);
      guard++;
    end
    repeat (10) @(negedge clk);
    check(done_cnt == start_done + 1, req, "done pulses", done_cnt - start_done, 1);
    check(busy == 1'b0, req, "busy after end", busy, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1", "busy/done in reset", {busy, done}, 0);
    check(wr_valid == 1'b0 && poll_err == 1'b0, "R1", "valid/err in reset", {wr_valid, poll_err}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 1'b0 && wr_valid == 1'b0, "R1", "idle after release", {busy, wr_valid}, 0);
    check(done_cnt == 0 && cap_n == 0, "R1", "no activity after release", cap_n, 0);
  endtask

  task automatic t_init();
    int d0, gap;
    d0 = done_cnt;
    start_seq(1, 0, 0, "R10");
    wait_end(d0, "R10");
    load_exp(0);
    compare_stream("R2");
    gap = (cap_n > 3) ? cap_t[3] - cap_t[2] : 0;
    check(gap >= RST_N && gap <= RST_N + 6, "R3", "reset wait gap", gap, RST_N);
  endtask

  task automatic t_up_stall();
    int d0;
    d0 = done_cnt;
    stall_en = 1'b1;
    start_seq(0, 1, 0, "R10");
    wait_end(d0, "R10");
    stall_en = 1'b0;
    load_exp(1);
    compare_stream("R4");
    check(hold_viol == 0, "R9", "offer changed before accept", hold_viol, 0);
  endtask

  task automatic t_down_fixed();
    int d0, gap;
    d0 = done_cnt;
    poll_mode = 1'b0;
    mute_flag = 1'b1;
    start_seq(0, 0, 1, "R10");
    wait_end(d0, "R10");
    mute_flag = 1'b0;
    load_exp(2);
    compare_stream("R5");
    gap = (cap_n > 2) ? cap_t[2] - cap_t[1] : 0;
    check(gap >= MUTE_N && gap <= MUTE_N + 6, "R6", "fixed mute gap", gap, MUTE_N);
    check(poll_err == 1'b0, "R6", "error flag in fixed mode", poll_err, 0);
  endtask

  task automatic t_down_poll();
    int d0, gap;
    d0 = done_cnt;
    poll_mode = 1'b1;
    start_seq(0, 0, 1, "R7");
    poll_mode = 1'b0;
    while (cap_n < 2) @(negedge clk);
    repeat (300) @(negedge clk);
    mute_flag = 1'b1;
    wait_end(d0, "R7");
    mute_flag = 1'b0;
    load_exp(2);
    compare_stream("R7");
    gap = (cap_n > 2) ? cap_t[2] - cap_t[1] : 0;
    check(gap >= 300 && gap <= 320, "R7", "polled mute gap", gap, 305);
    check(poll_err == 1'b0, "R7", "error flag after good poll", poll_err, 0);
  endtask

  task automatic t_down_timeout();
    int d0, gap;
    d0 = done_cnt;
    poll_mode = 1'b1;
    start_seq(0, 0, 1, "R8");
    poll_mode = 1'b0;
    wait_end(d0, "R8");
    load_exp(2);
    compare_stream("R8");
    gap = (cap_n > 2) ? cap_t[2] - cap_t[1] : 0;
    check(gap >= POLL_N && gap <= POLL_N + 6, "R8", "poll timeout gap", gap, POLL_N);
    check(poll_err == 1'b1, "R8", "error flag after timeout", poll_err, 1);
    d0 = done_cnt;
    start_seq(1, 0, 0, "R8");
    check(poll_err == 1'b0, "R8", "error cleared by next command", poll_err, 0);
    wait_end(d0, "R8");
  endtask

  task automatic t_busy_ignore();
    int d0, n_end;
    d0 = done_cnt;
    start_seq(0, 1, 0, "R11");
    while (cap_n < 2) @(negedge clk);
    pulse(0, 0, 1);
    pulse(1, 0, 0);
    wait_end(d0, "R11");
    load_exp(1);
    compare_stream("R11");
    n_end = cap_n;
    repeat (50) @(negedge clk);
    check(cap_n == n_end && busy == 1'b0, "R11", "writes after ignored commands", cap_n, n_end);
  endtask

  task automatic t_priority();
    int d0;
    d0 = done_cnt;
    start_seq(1, 1, 1, "R11");
    wait_end(d0, "R11");
    load_exp(0);
    compare_stream("R11");
    d0 = done_cnt;
    start_seq(0, 1, 1, "R11");
    wait_end(d0, "R11");
    load_exp(1);
    compare_stream("R11");
  endtask

  initial begin
    t_reset();
    t_init();
    t_up_stall();
    t_down_fixed();
    t_down_poll();
    t_down_timeout();
    t_busy_ignore();
    t_priority();
    summary();
    $finish;
  end

endmodule